// File: doc/BRIEF.md
# Serial Radio Packet Framer

This block turns a payload held in a transmit byte buffer into a framed serial bit stream for a radio modulator. After a start strobe it sends a run of alternating preamble bits, then a 16- or 32-bit synchronisation word. It then sends the payload bytes as the buffer supplies them: an optional length byte, an optional address byte and the data, none of which the block interprets beyond the length. It can follow them with a 16-bit CRC that it computes itself. The payload and CRC can optionally be scrambled with a PN9 whitening sequence. The preamble and sync word are never scrambled.

A bit tick from the modulator paces the output. Each tick moves exactly one bit onto the serial output, qualified by a one-cycle strobe. Payload bytes are pulled just in time through a valid/ready handshake. If the buffer has no byte when one is needed, the block abandons the packet and signals an abort. The same abort flag reports a length setting outside the buffer's capacity. A one-cycle done flag closes every completed packet.

Top module: `pkt_serializer`

## Requirements
- R1: After reset, `ser_stb`, `pkt_done`, `pkt_abort` and `in_ready` are all low.
- R2: A packet opens with 8×`cfg_pre_bytes` preamble bits alternating 1,0,1,0… starting with 1. A value of 0 sends no preamble.
- R3: The sync word follows the preamble MSB first. When `cfg_sync32`=0 the word is `cfg_sync_word[15:0]`; when `cfg_sync32`=1 it is `cfg_sync_word[31:0]`.
- R4: Payload bytes follow the sync word MSB first, in buffer order. Without whitening they are unchanged. `in_ready` is high only in a cycle with `bit_tick` high in which a new byte is needed. A byte is taken when `in_ready` and `in_valid` are both high.
- R5: When `cfg_var_len`=0 the payload is `cfg_fix_len` bytes, with a legal range of 1 to 64. When `cfg_var_len`=1 the first payload byte L is the length field, and the payload is L+1 bytes including that byte.
- R6: When `cfg_crc_en`=1, a CRC-16 follows the payload, high byte first. It uses polynomial 0x8005 (x^16+x^15+x^2+1) with initial value 0xFFFF. Every payload bit enters it MSB first, before any whitening. When `cfg_crc_en`=0 no CRC is sent.
- R7: When `cfg_white_en`=1, the block keeps a 9-bit state s, set to 0x1FF at the first payload byte. Each payload byte, and then each CRC byte in turn, is XORed with s[7:0]. After each such byte, s is stepped 8 times by s ← {s[0]^s[5], s[8:1]}.
- R8: Each `bit_tick` during a packet sends exactly one bit. `ser_stb` is high in the cycle after the tick, with `ser_bit` carrying that bit.
- R9: `pkt_done` is high for exactly one cycle, the cycle right after the strobe of the packet's last bit.
- R10: If `in_ready` is high while `in_valid` is low, `pkt_abort` pulses in the next cycle. The bit sent on that tick is the packet's last bit, and `pkt_done` does not pulse.
- R11: In fixed mode, a `cfg_fix_len` of 0 or above 64 aborts in the cycle after start with no bits sent. In variable mode, a length byte above 63 is taken and then aborts the packet before any payload bit is sent.
- R12: A start strobe while a packet is in progress has no effect on the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| bit_tick | input | 1 | One output bit per high cycle |
| cfg_pre_bytes | input | 4 | Preamble length in bytes |
| cfg_sync32 | input | 1 | 1: 32-bit sync word, 0: 16-bit |
| cfg_sync_word | input | 32 | Sync word value |
| cfg_crc_en | input | 1 | Append CRC-16 |
| cfg_white_en | input | 1 | Whiten payload and CRC |
| cfg_var_len | input | 1 | 1: first payload byte is the length |
| cfg_fix_len | input | 8 | Payload length in fixed mode |
| in_data | input | 8 | Payload byte from the buffer |
| in_valid | input | 1 | Buffer has a byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| ser_bit | output | 1 | Serial data bit |
| ser_stb | output | 1 | Serial bit strobe |
| pkt_done | output | 1 | Packet completed |
| pkt_abort | output | 1 | Packet abandoned (underflow or bad length) |

## Verification
The checker assumes that the configuration inputs stay constant from a start strobe until done or abort. It also assumes that `bit_tick` is a plain enable that the block never back-pressures. The bench changes configuration only between packets and drives the tick from a free-running divider. It drives `in_valid` straight from the presence of a byte in its own source queue, so an underflow happens only where a test deliberately leaves the queue short.

// File: rtl/pktser_pkg.sv
package pktser_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_PAY,
        PH_CRC,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic bit_v;
        logic stb;
        logic done;
        logic abort;
    } ser_out_t;

    localparam logic [15:0] CRC_POLY    = 16'h8005;
    localparam logic [15:0] CRC_INIT    = 16'hFFFF;
    localparam logic [8:0]  PN_INIT     = 9'h1FF;
    localparam logic [31:0] PRE_PATTERN = 32'hAAAA_AAAA;

    // Fold one byte into the CRC, most significant bit first.
    function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // Advance the PN9 generator by eight steps.
    function automatic logic [8:0] pn9_next8(input logic [8:0] s);
        logic [8:0] r;
        r = s;
        for (int i = 0; i < 8; i++) r = {r[0] ^ r[5], r[8:1]};
        return r;
    endfunction

endpackage

// File: rtl/pktser_crc16.sv
module pktser_crc16
    import pktser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_INIT;
        else if (en)      crc <= crc16_next(crc, data);
    end
endmodule

// File: rtl/pktser_pn9.sv
module pktser_pn9
    import pktser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       seed,
    input  logic       step,
    output logic [7:0] cur_byte,
    output logic [7:0] nxt_byte
);
    logic [8:0] st;
    logic [8:0] st_adv;

    assign st_adv   = pn9_next8(st);
    assign cur_byte = st[7:0];
    assign nxt_byte = st_adv[7:0];

    always_ff @(posedge clk) begin
        if (rst || seed) st <= PN_INIT;
        else if (step)   st <= st_adv;
    end
endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer
    import pktser_pkg::*;
#(
    parameter int MAX_PAY = 64,   // 1..255
    parameter int PRE_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bit_tick,
    input  logic [PRE_W-1:0] cfg_pre_bytes,
    input  logic             cfg_sync32,
    input  logic [31:0]      cfg_sync_word,
    input  logic             cfg_crc_en,
    input  logic             cfg_white_en,
    input  logic             cfg_var_len,
    input  logic [7:0]       cfg_fix_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             ser_bit,
    output logic             ser_stb,
    output logic             pkt_done,
    output logic             pkt_abort
);
    localparam int LEN_W   = $clog2(MAX_PAY + 1);
    localparam int PRE_CW  = $clog2((2 ** PRE_W - 1) * 8 + 1);
    localparam int CNT_W   = (PRE_CW > 6) ? PRE_CW : 6;
    localparam logic [8:0] MAX9 = 9'(MAX_PAY);

    phase_e           ph;
    ser_out_t         oq;
    logic [31:0]      sh;
    logic [CNT_W-1:0] left;
    logic [LEN_W-1:0] nbytes;
    logic [LEN_W-1:0] total;

    logic             emit, seg_end, need_byte, take, first_byte;
    logic             fix_bad, var_len_bad;
    logic [8:0]       len_plus1;
    logic [7:0]       tx_byte, wm_cur, wm_nxt;
    logic [15:0]      crc_q, crc_tx;
    logic [7:0]       pn_cur, pn_nxt;
    logic [31:0]      sync_sh;
    logic [CNT_W-1:0] sync_len;

    pktser_crc16 u_crc (
        .clk(clk), .rst(rst), .clear(ph == PH_IDLE && start),
        .en(take), .data(in_data), .crc(crc_q)
    );

    pktser_pn9 u_pn (
        .clk(clk), .rst(rst), .seed(ph == PH_IDLE && start),
        .step(take), .cur_byte(pn_cur), .nxt_byte(pn_nxt)
    );

    always_comb begin
        emit        = bit_tick && (ph inside {PH_PRE, PH_SYNC, PH_PAY, PH_CRC});
        seg_end     = emit && (left == CNT_W'(1));
        need_byte   = seg_end && (ph == PH_SYNC || (ph == PH_PAY && nbytes != total));
        take        = need_byte && in_valid;
        first_byte  = (nbytes == '0);
        len_plus1   = {1'b0, in_data} + 9'd1;
        var_len_bad = cfg_var_len && first_byte && (len_plus1 > MAX9);
        fix_bad     = (cfg_fix_len == 8'd0) || ({1'b0, cfg_fix_len} > MAX9);
        wm_cur      = cfg_white_en ? pn_cur : 8'h00;
        wm_nxt      = cfg_white_en ? pn_nxt : 8'h00;
        tx_byte     = in_data ^ wm_cur;
        crc_tx      = {crc_q[15:8] ^ wm_cur, crc_q[7:0] ^ wm_nxt};
        sync_sh     = cfg_sync32 ? cfg_sync_word : {cfg_sync_word[15:0], 16'h0000};
        sync_len    = cfg_sync32 ? CNT_W'(32) : CNT_W'(16);
    end

    assign in_ready  = need_byte;
    assign ser_bit   = oq.bit_v;
    assign ser_stb   = oq.stb;
    assign pkt_done  = oq.done;
    assign pkt_abort = oq.abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            sh     <= '0;
            left   <= '0;
            nbytes <= '0;
            total  <= '0;
            oq     <= '0;
        end else begin
            oq.stb   <= emit;
            oq.bit_v <= emit & sh[31];
            oq.done  <= 1'b0;
            oq.abort <= 1'b0;
            if (emit) begin
                left <= left - CNT_W'(1);
                sh   <= (ph == PH_PRE) ? {sh[30:0], sh[31]} : {sh[30:0], 1'b0};
            end
            unique case (ph)
                PH_IDLE: if (start) begin
                    if (!cfg_var_len && fix_bad) begin
                        oq.abort <= 1'b1;
                    end else begin
                        nbytes <= '0;
                        total  <= cfg_fix_len[LEN_W-1:0];
                        if (cfg_pre_bytes != '0) begin
                            ph   <= PH_PRE;
                            sh   <= PRE_PATTERN;
                            left <= CNT_W'({cfg_pre_bytes, 3'b000});
                        end else begin
                            ph   <= PH_SYNC;
                            sh   <= sync_sh;
                            left <= sync_len;
                        end
                    end
                end
                PH_PRE: if (seg_end) begin
                    ph   <= PH_SYNC;
                    sh   <= sync_sh;
                    left <= sync_len;
                end
                PH_SYNC, PH_PAY: if (seg_end) begin
                    if (need_byte) begin
                        if (!in_valid || var_len_bad) begin
                            ph       <= PH_IDLE;
                            oq.abort <= 1'b1;
                        end else begin
                            ph     <= PH_PAY;
                            sh     <= {tx_byte, 24'h000000};
                            left   <= CNT_W'(8);
                            nbytes <= nbytes + LEN_W'(1);
                            if (cfg_var_len && first_byte) total <= len_plus1[LEN_W-1:0];
                        end
                    end else if (cfg_crc_en) begin
                        ph   <= PH_CRC;
                        sh   <= {crc_tx, 16'h0000};
                        left <= CNT_W'(16);
                    end else begin
                        ph <= PH_FIN;
                    end
                end
                PH_CRC: if (seg_end) ph <= PH_FIN;
                PH_FIN: begin
                    oq.done <= 1'b1;
                    ph      <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pktser_chk.sv
module pktser_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic in_valid,
    input logic in_ready,
    input logic ser_stb,
    input logic pkt_done,
    input logic pkt_abort
);
    assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        ser_stb |-> $past(bit_tick));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);

    assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(ser_stb));

    assert_underflow_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> pkt_abort);

    assert_quiet_after_abort_R10: assert property (@(posedge clk) disable iff (rst)
        pkt_abort |=> !ser_stb);

    assert_ready_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_tick);

    always_ff @(posedge clk) begin
        if (!rst) begin
            assert_done_abort_excl_R9: assert (!(pkt_done && pkt_abort));
        end
    end
endmodule

bind pkt_serializer pktser_chk u_chk (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_ready(in_ready), .ser_stb(ser_stb), .pkt_done(pkt_done), .pkt_abort(pkt_abort)
);

// File: tb/pkt_serializer_tb.sv
`timescale 1ns/1ps
module pkt_serializer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bit_tick = 1'b0;
    logic [3:0] cfg_pre_bytes = 4'd2;
    logic cfg_sync32 = 1'b0;
    logic [31:0] cfg_sync_word = 32'h0000_D391;
    logic cfg_crc_en = 1'b0, cfg_white_en = 1'b0, cfg_var_len = 1'b0;
    logic [7:0] cfg_fix_len = 8'd4;
    logic [7:0] in_data = 8'h00;
    logic in_valid = 1'b0;
    logic in_ready, ser_bit, ser_stb, pkt_done, pkt_abort;

    pkt_serializer u_dut (
        .clk(clk), .rst(rst), .start(start), .bit_tick(bit_tick),
        .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync32(cfg_sync32), .cfg_sync_word(cfg_sync_word),
        .cfg_crc_en(cfg_crc_en), .cfg_white_en(cfg_white_en), .cfg_var_len(cfg_var_len),
        .cfg_fix_len(cfg_fix_len), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .ser_bit(ser_bit), .ser_stb(ser_stb), .pkt_done(pkt_done), .pkt_abort(pkt_abort)
    );

    always #2.5 clk = ~clk;

    int n_tot = 0, n_bad = 0;
    int cyc = 0, last_stb_cyc = -10, done_cnt = 0, abort_cnt = 0;
    int tick_div = 2, tick_ctr = 0;
    logic exp_q[$];
    logic [7:0] src_q[$];
    logic [7:0] pl_q[$];
    logic tick_q = 1'b0;
    logic exp_b;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    // Scoreboard driver: expected bit stream from the requirements.
    task automatic build_exp(input bit with_crc);
        logic [15:0] c;
        logic [8:0] s;
        logic [7:0] w;
        logic fb;
        exp_q.delete();
        for (int i = 0; i < 8 * cfg_pre_bytes; i++) exp_q.push_back((i % 2) == 0);
        if (cfg_sync32) for (int i = 31; i >= 0; i--) exp_q.push_back(cfg_sync_word[i]);
        else            for (int i = 15; i >= 0; i--) exp_q.push_back(cfg_sync_word[i]);
        c = 16'hFFFF;
        s = 9'h1FF;
        foreach (pl_q[k]) begin
            w = cfg_white_en ? s[7:0] : 8'h00;
            push_byte(pl_q[k] ^ w);
            for (int j = 0; j < 8; j++) s = {s[0] ^ s[5], s[8:1]};
            for (int i = 7; i >= 0; i--) begin
                fb = c[15] ^ pl_q[k][i];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
        end
        if (with_crc) begin
            w = cfg_white_en ? s[7:0] : 8'h00;
            push_byte(c[15:8] ^ w);
            for (int j = 0; j < 8; j++) s = {s[0] ^ s[5], s[8:1]};
            w = cfg_white_en ? s[7:0] : 8'h00;
            push_byte(c[7:0] ^ w);
        end
    endtask

    // Tick and byte source.
    always @(negedge clk) begin
        tick_ctr++;
        bit_tick = (tick_ctr % tick_div) == 0;
        in_valid = src_q.size() != 0;
        in_data  = in_valid ? src_q[0] : 8'h00;
        #1;
        if (in_ready && in_valid) void'(src_q.pop_front());
    end

    always @(posedge clk) tick_q <= bit_tick;

    // Monitor: pop and compare each emitted bit.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ser_stb) begin
                chk(tick_q, "R8", "strobe without preceding tick", 0, 1);
                last_stb_cyc = cyc;
                if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected serial bit", ser_bit, 0);
                else begin
                    exp_b = exp_q.pop_front();
                    chk(ser_bit == exp_b, "R4", "serial bit", ser_bit, exp_b);
                end
            end
            if (pkt_done) begin
                done_cnt++;
                chk(cyc == last_stb_cyc + 1, "R9", "done cycle", cyc, last_stb_cyc + 1);
            end
            if (pkt_abort) abort_cnt++;
        end
    end

    task automatic run_pkt(input string req, input int restart_at, input int exp_done, input int exp_abort);
        int d0, a0;
        d0 = done_cnt;
        a0 = abort_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            start = (c == restart_at);
            if (done_cnt != d0 || abort_cnt != a0) break;
        end
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected bits left unsent", exp_q.size(), 0);
        chk(done_cnt - d0 == exp_done, req, "done pulses", done_cnt - d0, exp_done);
        chk(abort_cnt - a0 == exp_abort, req, "abort pulses", abort_cnt - a0, exp_abort);
        chk(src_q.size() == 0, req, "source bytes not taken", src_q.size(), 0);
    endtask

    task automatic set_payload(input int n, input int seed);
        pl_q.delete();
        src_q.delete();
        for (int i = 0; i < n; i++) pl_q.push_back(8'((seed + i * 37) ^ (i << 3)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!ser_stb && !pkt_done && !pkt_abort && !in_ready, "R1", "idle outputs",
            {ser_stb, pkt_done, pkt_abort, in_ready}, 0);

        // R2 R3 R4 R5: fixed length, 16-bit sync, plain bytes
        cfg_pre_bytes = 4'd2; cfg_sync32 = 1'b0; cfg_sync_word = 32'hFFFF_D391;
        cfg_crc_en = 0; cfg_white_en = 0; cfg_var_len = 0; cfg_fix_len = 8'd4;
        set_payload(4, 8'h3C); build_exp(0); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R3", -1, 1, 0);

        // R6: CRC appended, 32-bit sync
        cfg_pre_bytes = 4'd4; cfg_sync32 = 1'b1; cfg_sync_word = 32'h9E5A_C3D1;
        cfg_crc_en = 1; cfg_fix_len = 8'd3;
        set_payload(3, 8'h11); build_exp(1); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R6", -1, 1, 0);

        // R7 R5: variable length (length byte 2 -> 3 bytes), whitening, tick every cycle
        tick_div = 1;
        cfg_pre_bytes = 4'd3; cfg_sync32 = 1'b0; cfg_var_len = 1; cfg_white_en = 1; cfg_fix_len = 8'd9;
        pl_q.delete(); src_q.delete();
        pl_q.push_back(8'h02); pl_q.push_back(8'h5A); pl_q.push_back(8'hC3);
        build_exp(1); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R7", -1, 1, 0);

        // R5: largest fixed payload, whitening and CRC
        tick_div = 3;
        cfg_pre_bytes = 4'd1; cfg_var_len = 0; cfg_fix_len = 8'd64;
        set_payload(64, 8'h77); build_exp(1); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R5", -1, 1, 0);

        // R2: no preamble, variable length with L=0
        tick_div = 2;
        cfg_pre_bytes = 4'd0; cfg_var_len = 1; cfg_white_en = 0;
        pl_q.delete(); src_q.delete(); pl_q.push_back(8'h00);
        build_exp(1); src_q.push_back(8'h00);
        run_pkt("R2", -1, 1, 0);

        // R12: start while busy is ignored
        cfg_pre_bytes = 4'd2; cfg_var_len = 0; cfg_fix_len = 8'd3; cfg_crc_en = 0;
        set_payload(3, 8'hA5); build_exp(0); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R12", 30, 1, 0);

        // R10: buffer runs dry after two of five bytes
        cfg_fix_len = 8'd5; cfg_white_en = 1;
        set_payload(2, 8'h42); build_exp(0); foreach (pl_q[i]) src_q.push_back(pl_q[i]);
        run_pkt("R10", -1, 0, 1);

        // R11: variable length byte 64 exceeds the buffer
        cfg_var_len = 1; cfg_crc_en = 1;
        pl_q.delete(); src_q.delete(); build_exp(0); src_q.push_back(8'h40);
        run_pkt("R11", -1, 0, 1);

        // R11: fixed length 0 and 65
        cfg_var_len = 0; cfg_fix_len = 8'd0;
        pl_q.delete(); src_q.delete(); exp_q.delete();
        run_pkt("R11", -1, 0, 1);
        cfg_fix_len = 8'd65;
        run_pkt("R11", -1, 0, 1);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule